// File: doc/BRIEF.md
# Down-Counting Timer with Two Match Points

A single timer channel that counts down from a programmable reload value. It wraps back to that value after passing zero and keeps running. Each step of the count is gated by a tick. The tick is either every cycle of the block's own clock or a one-cycle strobe from a slower external source. Which one is used is chosen by a control bit.

Two match values are compared with the count after each step, and the two may hold any values relative to each other. A third event fires when the count steps to zero, if overflow interrupts are on or if either match value is zero. Every event inverts the interrupt line, so software or a downstream edge detector treats both edges as a request.

Software reaches the channel through a small register port. It can read and write the current count, the reload value, both match values and a control word holding enable, clock-source select and overflow-interrupt enable.

Top module: `dmatch_timer`

## Requirements
- R1: A synchronous active-high reset sets the count, reload, both match values, the control word and the interrupt line to zero.
- R2: A control write that sets enable (control bit 0) while the channel is disabled loads the count with the reload value on that clock edge. A control write that keeps enable set while already enabled does not reload.
- R3: While enabled, each tick lowers a nonzero count by one, and a tick on a count of zero loads the reload value.
- R4: With control bit 1 clear, a tick occurs on every clock cycle. With control bit 1 set, a tick occurs only in cycles where ext_strobe is high.
- R5: When a tick produces a nonzero new count equal to match A or match B, one event occurs. If both match values are equal, it is still a single event.
- R6: When a tick produces a new count of zero, an event occurs if control bit 2 (overflow enable) is set, or if match A or match B is zero. Otherwise no event occurs.
- R7: Each event inverts irq one cycle later, and irq never changes in a cycle without an event.
- R8: A write to the count register while enabled replaces the count, with no event in that cycle. A write to the count register while disabled is ignored.
- R9: While disabled, the count holds and no events occur. A control write that clears enable stops counting from the next cycle on.
- R10: A match value written while running is used from the next clock cycle on, within the same count period.
- R11: With a reload value of zero the count stays at zero. Each tick then raises an event only under the R6 condition.
- R12: Register selects are 0 count, 1 reload, 2 match A, 3 match B, 4 control (bit 0 enable, bit 1 external tick, bit 2 overflow enable). rd_data returns the selected register, zero-extended, and selects 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the bus-rate tick source |
| rst | input | 1 | Synchronous active-high reset |
| ext_strobe | input | 1 | One-cycle external tick strobe, already in the clk domain |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | CNT_W | Read data, combinational from rd_sel |
| irq | output | 1 | Interrupt level, inverted on every event |

## Verification
The assertions take for granted that ext_strobe is already synchronous to clk and lasts one cycle. They also take for granted that only one register write happens per cycle, so a count write and a control write never meet in the same edge. The bench drives every input at the falling edge from a single task that issues at most one write per cycle. It keeps ext_strobe to isolated one-cycle pulses and keeps writes in the disabled state apart from the tick checks. The bench uses an 8-bit count, which keeps the reload and match sweep small enough to cover every ordering of the two match values against the reload value.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  typedef enum logic [2:0] {
    SEL_COUNT   = 3'd0,
    SEL_RELOAD  = 3'd1,
    SEL_MATCH_A = 3'd2,
    SEL_MATCH_B = 3'd3,
    SEL_CTRL    = 3'd4
  } dmt_sel_e;

  typedef struct packed {
    logic ovf_en;   // bit 2
    logic ext_sel;  // bit 1
    logic enable;   // bit 0
  } dmt_ctrl_t;

  localparam int CTRL_W = 3;

endpackage

// File: rtl/dmt_regs.sv
module dmt_regs import dmt_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] match_a_q,
  output logic [CNT_W-1:0] match_b_q,
  output dmt_ctrl_t        ctrl_q,
  output logic             start,
  output logic             cnt_wr
);

  dmt_ctrl_t ctrl_new;
  logic      ctrl_wr;

  assign ctrl_new = dmt_ctrl_t'(wr_data[CTRL_W-1:0]);
  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  // enable rising edge only: a repeated enable write does not restart
  assign start    = ctrl_wr && ctrl_new.enable && !ctrl_q.enable;
  // count writes only land while running
  assign cnt_wr   = wr_en && (wr_sel == SEL_COUNT) && ctrl_q.enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q  <= '0;
      match_a_q <= '0;
      match_b_q <= '0;
      ctrl_q    <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_RELOAD:  reload_q  <= wr_data;
        SEL_MATCH_A: match_a_q <= wr_data;
        SEL_MATCH_B: match_b_q <= wr_data;
        SEL_CTRL:    ctrl_q    <= ctrl_new;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/dmt_tick_sel.sv
module dmt_tick_sel (
  input  logic enable,
  input  logic ext_sel,
  input  logic ext_strobe,
  output logic tick
);

  assign tick = enable && (ext_sel ? ext_strobe : 1'b1);

endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] match_a,
  input  logic [CNT_W-1:0] match_b,
  input  logic             ovf_en,
  output logic [CNT_W-1:0] count,
  output logic             match_evt,
  output logic             zero_evt,
  output logic             evt
);

  function automatic logic [CNT_W-1:0] step_value(
    input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] rel);
    return (cur == '0) ? rel : cur - CNT_W'(1);
  endfunction

  function automatic logic match_hit(
    input logic [CNT_W-1:0] v, input logic [CNT_W-1:0] a,
    input logic [CNT_W-1:0] b);
    return (v != '0) && ((v == a) || (v == b));
  endfunction

  function automatic logic zero_hit(
    input logic [CNT_W-1:0] v, input logic ovf,
    input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return (v == '0) && (ovf || (a == '0) || (b == '0));
  endfunction

  logic [CNT_W-1:0] next_val;
  logic             advance;

  assign next_val  = step_value(count, reload);
  assign advance   = tick && !start && !cnt_wr;
  assign match_evt = advance && match_hit(next_val, match_a, match_b);
  assign zero_evt  = advance && zero_hit(next_val, ovf_en, match_a, match_b);
  assign evt       = match_evt || zero_evt;

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (start)   count <= reload;
    else if (cnt_wr)  count <= wr_data;
    else if (advance) count <= next_val;
  end

endmodule

// File: rtl/dmt_irq.sv
module dmt_irq (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (evt) irq <= ~irq;
  end

endmodule

// File: rtl/dmatch_timer.sv
module dmatch_timer import dmt_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_strobe,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);

  localparam int PAD_W = CNT_W - CTRL_W;

  logic [CNT_W-1:0] reload_q, match_a_q, match_b_q, count;
  dmt_ctrl_t        ctrl_q;
  logic             start, cnt_wr, tick;
  logic             match_evt, zero_evt, evt;

  dmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .reload_q(reload_q), .match_a_q(match_a_q), .match_b_q(match_b_q),
    .ctrl_q(ctrl_q), .start(start), .cnt_wr(cnt_wr)
  );

  dmt_tick_sel u_tick (
    .enable(ctrl_q.enable), .ext_sel(ctrl_q.ext_sel),
    .ext_strobe(ext_strobe), .tick(tick)
  );

  dmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .cnt_wr(cnt_wr), .wr_data(wr_data),
    .tick(tick), .reload(reload_q), .match_a(match_a_q), .match_b(match_b_q),
    .ovf_en(ctrl_q.ovf_en), .count(count), .match_evt(match_evt),
    .zero_evt(zero_evt), .evt(evt)
  );

  dmt_irq u_irq (.clk(clk), .rst(rst), .evt(evt), .irq(irq));

  always_comb begin
    case (rd_sel)
      SEL_COUNT:   rd_data = count;
      SEL_RELOAD:  rd_data = reload_q;
      SEL_MATCH_A: rd_data = match_a_q;
      SEL_MATCH_B: rd_data = match_b_q;
      SEL_CTRL:    rd_data = {{PAD_W{1'b0}}, ctrl_q};
      default:     rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dmt_checker.sv
module dmt_checker import dmt_pkg::*; #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             ext_strobe,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload_q,
  input dmt_ctrl_t        ctrl_q,
  input logic             tick,
  input logic             match_evt,
  input logic             zero_evt,
  input logic             evt
);

  logic en_wr, cnt_w;
  assign en_wr = wr_en && (wr_sel == SEL_CTRL) && wr_data[0];
  assign cnt_w = wr_en && (wr_sel == SEL_COUNT);

  assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.enable && en_wr) |=> (count == $past(reload_q)));

  assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_w && count != '0) |=> (count == $past(count) - CNT_W'(1)));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_w && count == '0) |=> (count == $past(reload_q)));

  assert_ext_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.ext_sel && !ext_strobe) |-> !tick);

  assert_single_kind_R5: assert property (@(posedge clk) disable iff (rst)
    !(match_evt && zero_evt));

  assert_irq_flip_R7: assert property (@(posedge clk) disable iff (rst)
    evt |=> (irq != $past(irq)));

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !evt |=> $stable(irq));

  assert_cnt_write_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.enable && cnt_w) |=> (count == $past(wr_data)));

  assert_cnt_write_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.enable && cnt_w) |-> !evt);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.enable && !en_wr) |=> $stable(count));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.enable |-> !evt);

endmodule

bind dmatch_timer dmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ext_strobe(ext_strobe), .irq(irq), .count(count), .reload_q(reload_q),
  .ctrl_q(ctrl_q), .tick(tick), .match_evt(match_evt), .zero_evt(zero_evt),
  .evt(evt)
);

// File: tb/test_dmatch_timer.sv
`timescale 1ns/1ps
module test_dmatch_timer;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ext_strobe = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_sel = 3'd0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_sel = 3'd0;
  logic [W-1:0] rd_data;
  logic         irq;

  int tests = 0;
  int fails = 0;

  // shadow state built from the requirements
  logic [W-1:0] m_reload = '0, m_ma = '0, m_mb = '0, m_cnt = '0;
  logic         m_en = 1'b0, m_ext = 1'b0, m_ovf = 1'b0, m_irq = 1'b0;

  always #5 clk = ~clk;

  dmatch_timer #(.CNT_W(W)) i_dmatch_timer (
    .clk(clk), .rst(rst), .ext_strobe(ext_strobe), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // apply one cycle of stimulus, advance the model, check count and irq
  task automatic cyc(input string tag, input bit w, input logic [2:0] s,
                     input logic [W-1:0] d, input bit stb);
    logic         tk;
    logic [W-1:0] n;
    logic         ev;
    wr_en = w; wr_sel = s; wr_data = d; ext_strobe = stb;
    tk = m_en && (m_ext ? stb : 1'b1);
    if (w && s == 3'd4 && d[0] && !m_en) m_cnt = m_reload;      // R2
    else if (w && s == 3'd0 && m_en) m_cnt = d;                 // R8
    else if (tk) begin                                          // R3
      n  = (m_cnt == 0) ? m_reload : m_cnt - 1;
      ev = (n == 0) ? (m_ovf || m_ma == 0 || m_mb == 0)         // R6
                    : (n == m_ma || n == m_mb);                 // R5
      m_cnt = n;
      if (ev) m_irq = ~m_irq;                                   // R7
    end
    if (w) begin
      case (s)
        3'd1: m_reload = d;
        3'd2: m_ma = d;
        3'd3: m_mb = d;
        3'd4: begin m_en = d[0]; m_ext = d[1]; m_ovf = d[2]; end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; ext_strobe = 1'b0;
    check({tag, " count"}, rd_data, m_cnt);
    check({tag, " irq"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_irq});
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 3'd0, '0, 1'b0);
  endtask

  task automatic rd_check(input string tag, input logic [2:0] s,
                          input logic [W-1:0] exp);
    rd_sel = s;
    #1;
    check(tag, rd_data, exp);
    rd_sel = 3'd0;
    #1;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every register and the interrupt line
    for (int s = 0; s < 8; s++) rd_check("R1 reset read", 3'(s), '0);
    check("R1 reset irq", {{(W-1){1'b0}}, irq}, '0);

    // R12: register map readback, unused selects read zero
    cyc("R12", 1'b1, 3'd1, 8'hA5, 1'b0);
    cyc("R12", 1'b1, 3'd2, 8'h3C, 1'b0);
    cyc("R12", 1'b1, 3'd3, 8'hC3, 1'b0);
    cyc("R12", 1'b1, 3'd4, 8'h06, 1'b0);
    rd_check("R12 reload", 3'd1, 8'hA5);
    rd_check("R12 match A", 3'd2, 8'h3C);
    rd_check("R12 match B", 3'd3, 8'hC3);
    rd_check("R12 control", 3'd4, 8'h06);
    rd_check("R12 unused", 3'd6, 8'h00);

    // R8: count write ignored while disabled
    cyc("R8 disabled write", 1'b1, 3'd0, 8'd77, 1'b0);
    rd_check("R8 disabled write ignored", 3'd0, 8'd0);

    // R3 R5 R6 R11: sweep of reload, both match values, overflow enable
    for (int rl = 0; rl < 7; rl++)
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 7; b++)
          for (int ov = 0; ov < 2; ov++) begin
            cyc("R9 stop", 1'b1, 3'd4, 8'd0, 1'b0);
            cyc("R3 setup", 1'b1, 3'd1, 8'(rl), 1'b0);
            cyc("R5 setup", 1'b1, 3'd2, 8'(a), 1'b0);
            cyc("R5 setup", 1'b1, 3'd3, 8'(b), 1'b0);
            cyc("R2 start", 1'b1, 3'd4, 8'(1 + 4 * ov), 1'b0);
            idle("R3/R5/R6/R11 sweep", 3 * (rl + 1) + 2);
          end

    // R9: disable holds count and irq
    cyc("R9", 1'b1, 3'd4, 8'd0, 1'b0);
    cyc("R9", 1'b1, 3'd1, 8'd100, 1'b0);
    cyc("R9", 1'b1, 3'd2, 8'd90, 1'b0);
    cyc("R9", 1'b1, 3'd3, 8'd95, 1'b0);
    cyc("R2", 1'b1, 3'd4, 8'd1, 1'b0);
    idle("R3 run", 8);
    cyc("R9 disable", 1'b1, 3'd4, 8'd0, 1'b0);
    idle("R9 hold", 6);

    // R2: enable again reloads; repeated enable write does not
    cyc("R2 restart", 1'b1, 3'd4, 8'd1, 1'b0);
    idle("R2 run", 4);
    cyc("R2 repeated enable", 1'b1, 3'd4, 8'd1, 1'b0);
    idle("R2 no reload", 3);

    // R8: count write while running, then counting from new value
    cyc("R8 running write", 1'b1, 3'd0, 8'd92, 1'b0);
    idle("R8 continue through match", 8);

    // R10: match rewrite mid-period takes effect
    cyc("R10 rewrite", 1'b1, 3'd2, 8'd70, 1'b0);
    idle("R10 hit new match", 20);

    // R4: external tick source with sparse strobes
    cyc("R4 stop", 1'b1, 3'd4, 8'd0, 1'b0);
    cyc("R4 setup", 1'b1, 3'd1, 8'd6, 1'b0);
    cyc("R4 setup", 1'b1, 3'd2, 8'd3, 1'b0);
    cyc("R4 setup", 1'b1, 3'd3, 8'd5, 1'b0);
    cyc("R4 start", 1'b1, 3'd4, 8'd7, 1'b0);
    for (int i = 0; i < 40; i++)
      cyc("R4 ext tick", 1'b0, 3'd0, '0, (i % 3) == 1);
    rd_check("R4 count after strobes", 3'd0, m_cnt);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule